// File: doc/BRIEF.md
# Audio DAC Power Sequencing Controller

This controller walks a stereo audio converter from its held-off condition to playback and back again. It watches a set of qualified indications: the external reset level, the internal power-on-reset release, master clock present, word-select and bit clocks present, clock ratio valid and clock ratio changed. From these it steps through a fixed order of power states. It drives enables for the charge pump, the filter and modulator core, the voltage reference and the output amplifiers. It also drives the weak output pull-downs, a mute control and a three-bit state code.

The charge-pump precharge and the power-up settle are timed by a down-counter clocked by the controller clock, which runs at the master-clock rate. Each interval is a parameter given in cycles. At elaboration, the sum of the two intervals is checked against the 50 ms start-up budget. Every indication passes through a parameterised synchroniser before the state machine sees it. With zero stages the synchroniser is omitted.

State codes: 0 held in reset, 1 powered down, 2 charge-pump precharge, 3 ratio detection, 4 muted power-up, 5 normal playback, 6 muted on a ratio fault.

Top module: `dac_pwr_seq`

## Requirements
- R1: While `ext_rst_n` or `por_rel` reads low, the state code is 0. In that state every enable is low, and `pulldn_en` and `mute` are high. This includes the case where the external reset is high but the power-on reset has not released.
- R2: When both reset indications read high, state 0 moves to state 1. State 1 holds while `mclk_ok` is low, with all enables low and the pull-downs and mute active.
- R3: In state 1, `mclk_ok` high moves the controller to state 2, where only `cp_en` is set. State 2 lasts at least CP_CYCLES cycles.
- R4: State 2 moves to state 3 only after the precharge interval has expired and `sclk_ok` is high. State 3 holds until `ratio_ok` is high.
- R5: `ratio_ok` high in state 3 moves the controller to state 4. State 4 sets `core_en`, `vref_en` and `amp_en`, and keeps `mute` and `pulldn_en` high for PU_CYCLES cycles.
- R6: When the power-up interval ends, the controller enters state 5. There `mute` and `pulldn_en` are low. The pull-downs fall only after the amplifiers were already powered in the preceding cycle.
- R7: In state 5, `ratio_chg` high or `ratio_ok` low moves the controller to state 6. State 6 keeps the enables, raises `mute` and leaves the pull-downs released. State 6 returns to state 5 once `ratio_ok` is high and `ratio_chg` is low.
- R8: A low on either reset indication returns the controller to state 0 from any state. This takes priority over every other event in the same cycle.
- R9: With resets released, `mclk_ok` low returns any state to state 1 and drops all enables. This takes priority over ratio events in the same cycle.
- R10: Each indication passes through SYNC_STAGES register stages. The state therefore reacts SYNC_STAGES+1 clock edges after an input change, and not earlier.
- R11: With all clocks and the ratio already valid, state 5 is reached SYNC_STAGES+3+CP_CYCLES+PU_CYCLES cycles after reset release. This count must be under 50 ms at MCLK_HZ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock at the master-clock rate |
| rst_n | input | 1 | Asynchronous logic reset, active low |
| ext_rst_n | input | 1 | External reset level, low holds the converter in reset |
| por_rel | input | 1 | Power-on reset released when high |
| mclk_ok | input | 1 | Master clock present |
| sclk_ok | input | 1 | Word-select and bit clocks present |
| ratio_ok | input | 1 | Clock ratio detected and valid |
| ratio_chg | input | 1 | Clock ratio changed |
| st_code | output | 3 | Current state code (0 to 6) |
| cp_en | output | 1 | Charge pump enable |
| core_en | output | 1 | Interpolation filter and modulator enable |
| vref_en | output | 1 | Voltage reference enable |
| amp_en | output | 1 | Output amplifier power |
| pulldn_en | output | 1 | Weak output pull-downs engaged |
| mute | output | 1 | Output mute |

## Verification
Two pairs of events can collide in one cycle. A reset indication and the loss of the master clock can fall together. In normal playback, a ratio change can coincide with master-clock loss. The bench drives each pair on the same falling edge. It expects reset to win in the first case, giving state 0, and clock loss to win in the second, giving state 1 rather than the mute state. A behavioural model compares every output on every cycle, and scenario checks time each transition against the synchroniser latency.

// File: rtl/dps_pkg.sv
package dps_pkg;
   typedef enum logic [2:0] {
      ST_RESET  = 3'd0,
      ST_PWRDN  = 3'd1,
      ST_INIT   = 3'd2,
      ST_DETECT = 3'd3,
      ST_PWRUP  = 3'd4,
      ST_NORMAL = 3'd5,
      ST_MUTE   = 3'd6
   } dps_state_e;

   localparam int unsigned DPS_NIND = 6;
   // indication vector bit positions
   localparam int unsigned IX_EXT   = 5;
   localparam int unsigned IX_POR   = 4;
   localparam int unsigned IX_MCLK  = 3;
   localparam int unsigned IX_SCLK  = 2;
   localparam int unsigned IX_ROK   = 1;
   localparam int unsigned IX_RCHG  = 0;
endpackage

// File: rtl/dps_sync.sv
module dps_sync #(
   parameter int unsigned WIDTH  = 6,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [WIDTH-1:0] stg [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < int'(STAGES); i++) stg[i] <= '0;
            end else begin
               stg[0] <= d;
               for (int i = 1; i < int'(STAGES); i++) stg[i] <= stg[i-1];
            end
         end
         assign q = stg[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/dps_timer.sv
module dps_timer #(
   parameter int unsigned CP_CYCLES = 200,
   parameter int unsigned PU_CYCLES = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ld_cp,
   input  logic ld_pu,
   output logic done
);
   localparam int unsigned MAXC = (CP_CYCLES > PU_CYCLES) ? CP_CYCLES : PU_CYCLES;
   localparam int unsigned TW   = $clog2(MAXC + 1);
   localparam logic [TW-1:0] CP_LD = TW'(CP_CYCLES - 1);
   localparam logic [TW-1:0] PU_LD = TW'(PU_CYCLES - 1);

   logic [TW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt <= '0;
      else if (ld_cp)        cnt <= CP_LD;
      else if (ld_pu)        cnt <= PU_LD;
      else if (cnt != '0)    cnt <= cnt - 1'b1;
   end

   assign done = (cnt == '0);

   assert_single_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(ld_cp && ld_pu));
endmodule

// File: rtl/dps_fsm.sv
module dps_fsm
   import dps_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [DPS_NIND-1:0] ind,
   input  logic       tmr_done,
   output logic       ld_cp,
   output logic       ld_pu,
   output dps_state_e st
);
   dps_state_e nxt;
   logic rst_ok, mclk_s, sclk_s, rok_s, rchg_s;

   assign rst_ok = ind[IX_EXT] & ind[IX_POR];
   assign mclk_s = ind[IX_MCLK];
   assign sclk_s = ind[IX_SCLK];
   assign rok_s  = ind[IX_ROK];
   assign rchg_s = ind[IX_RCHG];

   always_comb begin
      nxt   = st;
      ld_cp = 1'b0;
      ld_pu = 1'b0;
      if (!rst_ok)                nxt = ST_RESET;
      else if (st == ST_RESET)    nxt = ST_PWRDN;
      else if (!mclk_s)           nxt = ST_PWRDN;
      else begin
         unique case (st)
            ST_PWRDN:  begin nxt = ST_INIT; ld_cp = 1'b1; end
            ST_INIT:   if (tmr_done && sclk_s) nxt = ST_DETECT;
            ST_DETECT: if (rok_s) begin nxt = ST_PWRUP; ld_pu = 1'b1; end
            ST_PWRUP:  if (tmr_done) nxt = ST_NORMAL;
            ST_NORMAL: if (rchg_s || !rok_s) nxt = ST_MUTE;
            ST_MUTE:   if (rok_s && !rchg_s) nxt = ST_NORMAL;
            default:   nxt = ST_RESET;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= ST_RESET;
      else        st <= nxt;
   end

   assert_reset_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !rst_ok |=> st == ST_RESET);
   assert_mclk_loss_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_ok && !mclk_s) |=> st == ST_PWRDN);
   assert_precharge_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_INIT && !tmr_done) |=> st != ST_DETECT);
   assert_ratio_mute_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_NORMAL && rst_ok && mclk_s && rchg_s) |=> st == ST_MUTE);
endmodule

// File: rtl/dac_pwr_seq.sv
module dac_pwr_seq
   import dps_pkg::*;
#(
   parameter int unsigned CP_CYCLES   = 200,
   parameter int unsigned PU_CYCLES   = 100,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned MCLK_HZ     = 12_288_000,
   parameter int unsigned BUDGET_MS   = 50
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ext_rst_n,
   input  logic       por_rel,
   input  logic       mclk_ok,
   input  logic       sclk_ok,
   input  logic       ratio_ok,
   input  logic       ratio_chg,
   output logic [2:0] st_code,
   output logic       cp_en,
   output logic       core_en,
   output logic       vref_en,
   output logic       amp_en,
   output logic       pulldn_en,
   output logic       mute
);
   localparam longint START_CYC = longint'(CP_CYCLES) + longint'(PU_CYCLES)
                                  + longint'(SYNC_STAGES) + 3;
   localparam longint BUDGET_CYC = longint'(BUDGET_MS) * longint'(MCLK_HZ) / 1000;

   generate
      if (CP_CYCLES < 1 || PU_CYCLES < 1) begin : g_bad_interval
         $error("settling intervals must be at least one cycle");
      end
      if (SYNC_STAGES > 4) begin : g_bad_sync
         $error("synchroniser depth limited to four stages");
      end
      if (START_CYC >= BUDGET_CYC) begin : g_bad_budget
         $error("start-up sequence exceeds the time budget");
      end
   endgenerate

   logic [DPS_NIND-1:0] ind_raw, ind_s;
   logic       tmr_done, ld_cp, ld_pu;
   dps_state_e st;

   assign ind_raw = {ext_rst_n, por_rel, mclk_ok, sclk_ok, ratio_ok, ratio_chg};

   dps_sync #(.WIDTH(DPS_NIND), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(ind_raw), .q(ind_s));

   dps_timer #(.CP_CYCLES(CP_CYCLES), .PU_CYCLES(PU_CYCLES)) u_tmr (
      .clk(clk), .rst_n(rst_n), .ld_cp(ld_cp), .ld_pu(ld_pu), .done(tmr_done));

   dps_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .ind(ind_s), .tmr_done(tmr_done),
      .ld_cp(ld_cp), .ld_pu(ld_pu), .st(st));

   always_comb begin
      st_code   = st;
      cp_en     = 1'b0;
      core_en   = 1'b0;
      vref_en   = 1'b0;
      amp_en    = 1'b0;
      pulldn_en = 1'b1;
      mute      = 1'b1;
      unique case (st)
         ST_INIT, ST_DETECT: cp_en = 1'b1;
         ST_PWRUP: begin
            cp_en = 1'b1; core_en = 1'b1; vref_en = 1'b1; amp_en = 1'b1;
         end
         ST_NORMAL, ST_MUTE: begin
            cp_en = 1'b1; core_en = 1'b1; vref_en = 1'b1; amp_en = 1'b1;
            pulldn_en = 1'b0;
            mute = (st == ST_MUTE);
         end
         default: ;
      endcase
   end

   assert_pd_after_amp_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pulldn_en) |-> $past(amp_en));
   assert_amp_under_pd_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(amp_en) |-> (pulldn_en && mute));
endmodule

// File: tb/dac_pwr_seq_tb.sv
module dac_pwr_seq_tb;
   localparam int CP = 200;
   localparam int PU = 100;
   localparam int S  = 2;
   localparam int L  = S + 1;
   localparam longint MHZ = 12_288_000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ext_rst_n = 1'b0, por_rel = 1'b0, mclk_ok = 1'b0, sclk_ok = 1'b0;
   logic ratio_ok = 1'b0, ratio_chg = 1'b0;
   logic [2:0] st_code;
   logic cp_en, core_en, vref_en, amp_en, pulldn_en, mute;

   int nchk = 0, nfail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   dac_pwr_seq u_dut (
      .clk(clk), .rst_n(rst_n), .ext_rst_n(ext_rst_n), .por_rel(por_rel),
      .mclk_ok(mclk_ok), .sclk_ok(sclk_ok), .ratio_ok(ratio_ok), .ratio_chg(ratio_chg),
      .st_code(st_code), .cp_en(cp_en), .core_en(core_en), .vref_en(vref_en),
      .amp_en(amp_en), .pulldn_en(pulldn_en), .mute(mute));

   // behavioural reference model
   logic [5:0] q[$];
   int m_st = 0, m_age = 0;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q.delete();
         for (int i = 0; i < S; i++) q.push_front(6'b0);
         m_st = 0; m_age = 0;
      end else begin
         logic [5:0] d;
         int nx;
         if (S == 0) d = {ext_rst_n, por_rel, mclk_ok, sclk_ok, ratio_ok, ratio_chg};
         else begin
            d = q[$];
            void'(q.pop_back());
            q.push_front({ext_rst_n, por_rel, mclk_ok, sclk_ok, ratio_ok, ratio_chg});
         end
         nx = m_st;
         if (!(d[5] && d[4])) nx = 0;
         else if (m_st == 0) nx = 1;
         else if (!d[3]) nx = 1;
         else case (m_st)
            1: nx = 2;
            2: if (m_age >= CP - 1 && d[2]) nx = 3;
            3: if (d[1]) nx = 4;
            4: if (m_age >= PU - 1) nx = 5;
            5: if (d[0] || !d[1]) nx = 6;
            6: if (d[1] && !d[0]) nx = 5;
            default: nx = 0;
         endcase
         if (nx != m_st) m_age = 0; else m_age++;
         m_st = nx;
      end
   end

   function automatic logic [8:0] exp_vec(int s);
      logic on;
      on = (s >= 4);
      return {3'(s), (s >= 2), on, on, on, !(s == 5 || s == 6), (s != 5)};
   endfunction

   function automatic string tag_of(int s);
      case (s)
         0: return "R1"; 1: return "R2"; 2: return "R3"; 3: return "R4";
         4: return "R5"; 5: return "R6"; default: return "R7";
      endcase
   endfunction

   always @(negedge clk) begin
      if (rst_n && !done) begin
         logic [8:0] act, ex;
         act = {st_code, cp_en, core_en, vref_en, amp_en, pulldn_en, mute};
         ex  = exp_vec(m_st);
         nchk++;
         if (act !== ex) begin
            nfail++;
            $display("FAIL %s per-cycle outputs act=%b exp=%b", tag_of(m_st), act, ex);
         end
      end
   end

   task automatic step(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(int exp, string tag);
      nchk++;
      if (st_code !== 3'(exp)) begin
         nfail++;
         $display("FAIL %s state act=%0d exp=%0d", tag, st_code, exp);
      end
   endtask

   task automatic chk_bit(logic act, logic exp, string tag);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s output act=%b exp=%b", tag, act, exp);
      end
   endtask

   initial begin
      step(3);
      rst_n = 1'b1;
      step(1);
      chk(0, "R1"); chk_bit(pulldn_en, 1'b1, "R1"); chk_bit(mute, 1'b1, "R1");
      // external reset high, power-on reset still holding
      ext_rst_n = 1'b1;
      step(L + 2);
      chk(0, "R1");
      por_rel = 1'b1;
      step(L - 1); chk(0, "R10");
      step(1);     chk(1, "R10");
      step(20);    chk(1, "R2"); chk_bit(cp_en, 1'b0, "R2");
      // master clock arrives, serial clocks absent
      mclk_ok = 1'b1;
      step(L); chk(2, "R3"); chk_bit(cp_en, 1'b1, "R3"); chk_bit(amp_en, 1'b0, "R3");
      step(CP + 5); chk(2, "R4");
      sclk_ok = 1'b1;
      step(L); chk(3, "R4");
      step(10); chk(3, "R4");
      ratio_ok = 1'b1;
      step(L); chk(4, "R5");
      chk_bit(amp_en, 1'b1, "R5"); chk_bit(pulldn_en, 1'b1, "R5"); chk_bit(mute, 1'b1, "R5");
      step(PU - 1); chk(4, "R5");
      step(1); chk(5, "R6"); chk_bit(pulldn_en, 1'b0, "R6"); chk_bit(mute, 1'b0, "R6");
      // ratio change pulse, then ratio loss
      ratio_chg = 1'b1;
      step(L); chk(6, "R7"); chk_bit(mute, 1'b1, "R7"); chk_bit(pulldn_en, 1'b0, "R7");
      ratio_chg = 1'b0;
      step(L); chk(5, "R7");
      ratio_ok = 1'b0;
      step(L); chk(6, "R7");
      step(5); chk(6, "R7");
      ratio_ok = 1'b1;
      step(L); chk(5, "R7");
      // master clock loss in playback
      mclk_ok = 1'b0;
      step(L); chk(1, "R9"); chk_bit(amp_en, 1'b0, "R9");
      mclk_ok = 1'b1;
      step(L); chk(2, "R9");
      // reset and clock loss in the same cycle
      ext_rst_n = 1'b0; mclk_ok = 1'b0;
      step(L); chk(0, "R8");
      // full bring-up with clocks valid
      ext_rst_n = 1'b1; mclk_ok = 1'b1;
      step(L + 2 + CP + PU - 1); chk(4, "R11");
      step(1); chk(5, "R11");
      nchk++;
      if (!(longint'(L + 2 + CP + PU) * 1000 < 50 * MHZ)) begin
         nfail++;
         $display("FAIL R11 budget act=%0d exp<%0d", (L + 2 + CP + PU) * 1000, 50 * MHZ);
      end
      // ratio change and clock loss together
      ratio_chg = 1'b1; mclk_ok = 1'b0;
      step(L); chk(1, "R9");
      ratio_chg = 1'b0; mclk_ok = 1'b1;
      step(L + CP + 2); chk(4, "R5");
      por_rel = 1'b0;
      step(L); chk(0, "R8"); chk_bit(core_en, 1'b0, "R8");
      step(2);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         nchk++; nfail++;
         $display("FAIL watchdog act=running exp=finished");
         $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
         $finish;
      end
   end
endmodule